// File: doc/BRIEF.md
# Fan tachometer period counter

This block measures how long a fan takes to complete one revolution. It counts ticks of a 90 kHz time base, where each tick stands for 11.111 µs. The count runs from one rising edge of the tachometer signal to the rising edge two pulses later, which covers one revolution of a fan that gives two pulses per turn. The result is a 16-bit unsigned period. Software turns it into RPM by dividing 5,400,000 by the reading. The reading is exposed as two bytes, and the pair stays coherent across a low-byte read followed by a high-byte read.

A measurement engine is built around a five-state machine. `ST_ARM` waits for a first rising edge. `ST_HALF` counts until the middle edge, then moves to `ST_FULL`. `ST_FULL` counts until the closing edge. That edge publishes the count and returns the machine to `ST_HALF`, because the closing edge also opens the next measurement. If the count reaches the stall code before the closing edge arrives, the machine publishes that code and moves to `ST_STALL`. It stays there until a rising edge restarts it in `ST_HALF`. A PWM duty of zero forces `ST_HOLD` from any state. In `ST_HOLD` nothing is counted and the reading is kept. When the duty becomes non-zero again, the machine leaves `ST_HOLD` for `ST_ARM`.

The read side publishes each finished result, unless a byte pair is half read. In that case the result waits in a shadow register and is published at the clock edge that accepts the high-byte read.

Top module: `fan_tach_period`

## Requirements
- R1: The tach input passes through two synchronizing flops, and only rising edges count. The finished reading equals the number of clocks with `tick_90k` high that fall after the opening edge's clock, up to and including the closing edge's clock. The closing edge is the second rising edge after the opening one.
- R2: The clock edge that finishes one measurement also opens the next one, so a steady tach signal gives one new reading per revolution.
- R3: After reset, the reading is 0xFFFF, `stall` is 0 and `valid` is 0.
- R4: The count may reach the stall code before the closing edge arrives. The stall code depends on `dur_sel`:
  - `dur_sel` 2'b11 or 2'b10 gives 0xFFFF.
  - 2'b01 gives 0xFFFE.
  - 2'b00 gives 0xFFFC.
  
  When the count reaches that code, the code is published and the internal stall flag is set. A later rising edge restarts counting. The flag clears when a measurement completes normally.
- R5: While `pwm_duty` is 8'h00, no count advances and no new result is published. The held reading stays in place. When the duty becomes non-zero again, a fresh measurement waits for a new opening edge.
- R6: `rd_lo_data` shows bits 7:0 of the published reading. A `rd_lo` strobe latches bits 15:8. Until a `rd_hi` strobe is accepted, `rd_hi_data` shows the latched value.
- R7: A result that finishes while a byte pair is pending is kept in a shadow register. It is published at the edge that accepts `rd_hi`. `valid` is high for one cycle after every edge that changes the published reading.
- R8: `stall` is the internal stall flag gated by `fan_en`. Measurement does not depend on `fan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_90k | input | 1 | One-clock enable at the 90 kHz count rate |
| tach_in | input | 1 | Raw tachometer input, asynchronous |
| fan_en | input | 1 | Fan enable; gates the stall indication only |
| pwm_duty | input | 8 | Current PWM duty; 8'h00 suspends measurement |
| dur_sel | input | 2 | Measurement duration setting; selects the stall code |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_lo_data | output | 8 | Low byte of the published reading |
| rd_hi_data | output | CNT_W-8 | High byte, latched while a pair is pending |
| stall | output | 1 | Stall indication |
| valid | output | 1 | One-cycle pulse after each publish |

## Verification
A tach level sampled at clock edge k reaches the edge detector at edge k+2. The measurement engine acts on it at that same edge. The new reading and `valid` appear right after that edge when no pair is pending. When a pair is pending, they appear right after the edge that accepts `rd_hi`. `rd_lo_data` and the latched high byte change immediately after the `rd_lo` edge. `stall` follows `fan_en` within the same cycle.

The bench's reference model follows these exact edge counts and compares all four outputs at every falling edge, half a period after the edge that updates them. The directed reads and the settle times are sized so that they land on finished revolutions.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_HALF,
        ST_FULL,
        ST_STALL,
        ST_HOLD
    } meas_state_e;

    // Number of low bits cleared in the all-ones stall code for a duration setting
    function automatic logic [1:0] stall_clear_bits(input logic [1:0] dur);
        if (dur[1])
            return 2'd0;
        else if (dur[0])
            return 2'd1;
        else
            return 2'd2;
    endfunction

endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[STAGES-1:0], tach_raw};
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/tach_period_fsm.sv
module tach_period_fsm
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    input  logic             duty_zero,
    input  logic [1:0]       dur_sel,
    output logic             res_pulse,
    output logic [CNT_W-1:0] res_val,
    output logic             sat_evt,
    output logic             stall_q
);
    localparam int EXT_W = CNT_W + 1;

    meas_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             stall_d;
    logic [CNT_W-1:0] sat_code;
    logic [EXT_W-1:0] cnt_inc;
    logic             at_limit;

    assign sat_code = {CNT_W{1'b1}} << stall_clear_bits(dur_sel);
    assign cnt_inc  = {1'b0, cnt_q} + EXT_W'(tick);
    assign at_limit = cnt_inc >= {1'b0, sat_code};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            stall_q <= stall_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        stall_d   = stall_q;
        res_pulse = 1'b0;
        res_val   = sat_code;
        sat_evt   = 1'b0;
        if (duty_zero) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ST_ARM;
                ST_ARM, ST_STALL: begin
                    if (rise) begin
                        state_d = ST_HALF;
                        cnt_d   = '0;
                    end
                end
                ST_HALF, ST_FULL: begin
                    if (rise && state_q == ST_FULL) begin
                        res_pulse = 1'b1;
                        res_val   = at_limit ? sat_code : cnt_inc[CNT_W-1:0];
                        stall_d   = 1'b0;
                        cnt_d     = '0;
                        state_d   = ST_HALF;
                    end else if (at_limit) begin
                        res_pulse = 1'b1;
                        res_val   = sat_code;
                        sat_evt   = 1'b1;
                        stall_d   = 1'b1;
                        cnt_d     = sat_code;
                        state_d   = ST_STALL;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                        if (rise)
                            state_d = ST_FULL;
                    end
                end
                default: state_d = ST_ARM;
            endcase
        end
    end
endmodule

// File: rtl/tach_read_port.sv
module tach_read_port #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_pulse,
    input  logic [CNT_W-1:0] res_val,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [7:0]       lo_data,
    output logic [CNT_W-9:0] hi_data,
    output logic             lock_q,
    output logic             valid_q
);
    localparam int HI_W = CNT_W - 8;

    logic [CNT_W-1:0] pub_q, shadow_q;
    logic             pend_q;
    logic [HI_W-1:0]  latch_q;
    logic             release_rd;

    assign release_rd = rd_hi & lock_q & ~rd_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pub_q    <= '1;
            shadow_q <= '0;
            pend_q   <= 1'b0;
            lock_q   <= 1'b0;
            latch_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (release_rd) begin
                lock_q <= 1'b0;
                pend_q <= 1'b0;
                if (res_pulse) begin
                    pub_q   <= res_val;
                    valid_q <= 1'b1;
                end else if (pend_q) begin
                    pub_q   <= shadow_q;
                    valid_q <= 1'b1;
                end
            end else if (res_pulse) begin
                if (lock_q || rd_lo) begin
                    shadow_q <= res_val;
                    pend_q   <= 1'b1;
                end else begin
                    pub_q   <= res_val;
                    valid_q <= 1'b1;
                end
            end
            if (rd_lo) begin
                lock_q  <= 1'b1;
                latch_q <= pub_q[CNT_W-1:8];
            end
        end
    end

    assign lo_data = pub_q[7:0];
    assign hi_data = lock_q ? latch_q : pub_q[CNT_W-1:8];
endmodule

// File: rtl/fan_tach_period.sv
module fan_tach_period #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_90k,
    input  logic             tach_in,
    input  logic             fan_en,
    input  logic [7:0]       pwm_duty,
    input  logic [1:0]       dur_sel,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [7:0]       rd_lo_data,
    output logic [CNT_W-9:0] rd_hi_data,
    output logic             stall,
    output logic             valid
);
    logic             rise_w;
    logic             res_pulse_w;
    logic [CNT_W-1:0] res_val_w;
    logic             sat_evt_w;
    logic             stall_flag_w;
    logic             lock_w;

    tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tach_raw (tach_in),
        .rise     (rise_w)
    );

    tach_period_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_90k),
        .rise      (rise_w),
        .duty_zero (pwm_duty == 8'h00),
        .dur_sel   (dur_sel),
        .res_pulse (res_pulse_w),
        .res_val   (res_val_w),
        .sat_evt   (sat_evt_w),
        .stall_q   (stall_flag_w)
    );

    tach_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_pulse (res_pulse_w),
        .res_val   (res_val_w),
        .rd_lo     (rd_lo),
        .rd_hi     (rd_hi),
        .lo_data   (rd_lo_data),
        .hi_data   (rd_hi_data),
        .lock_q    (lock_w),
        .valid_q   (valid)
    );

    assign stall = stall_flag_w & fan_en;
endmodule

// File: rtl/fan_tach_period_chk.sv
module fan_tach_period_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       pwm_duty,
    input logic [1:0]       dur_sel,
    input logic             rd_lo,
    input logic             rd_hi,
    input logic [CNT_W-9:0] rd_hi_data,
    input logic             valid,
    input logic             lock_w,
    input logic             sat_evt_w,
    input logic [CNT_W-1:0] res_val_w,
    input logic             stall_flag_w
);
    logic [CNT_W-1:0] exp_code;
    always_comb begin
        case (dur_sel)
            2'b00:   exp_code = {{(CNT_W-2){1'b1}}, 2'b00};
            2'b01:   exp_code = {{(CNT_W-1){1'b1}}, 1'b0};
            default: exp_code = {CNT_W{1'b1}};
        endcase
    end

    assert_hi_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w && !rd_lo && !rd_hi) |=> $stable(rd_hi_data));

    assert_no_publish_suspended_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_duty == 8'h00 && !rd_hi) |=> !valid);

    assert_valid_only_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !lock_w);

    assert_stall_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt_w |-> (res_val_w == exp_code));

    assert_stall_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt_w |=> stall_flag_w);
endmodule

bind fan_tach_period fan_tach_period_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_duty     (pwm_duty),
    .dur_sel      (dur_sel),
    .rd_lo        (rd_lo),
    .rd_hi        (rd_hi),
    .rd_hi_data   (rd_hi_data),
    .valid        (valid),
    .lock_w       (lock_w),
    .sat_evt_w    (sat_evt_w),
    .res_val_w    (res_val_w),
    .stall_flag_w (stall_flag_w)
);

// File: tb/fan_tach_period_tb.sv
module fan_tach_period_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_90k = 1'b0;
    logic       tach_in = 1'b0;
    logic       fan_en = 1'b1;
    logic [7:0] pwm_duty = 8'h80;
    logic [1:0] dur_sel = 2'b11;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_lo_data;
    logic [7:0] rd_hi_data;
    logic       stall;
    logic       valid;

    always #4 clk = ~clk;

    fan_tach_period u_dut (
        .clk(clk), .rst_n(rst_n), .tick_90k(tick_90k), .tach_in(tach_in),
        .fan_en(fan_en), .pwm_duty(pwm_duty), .dur_sel(dur_sel),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_lo_data(rd_lo_data),
        .rd_hi_data(rd_hi_data), .stall(stall), .valid(valid)
    );

    // Stimulus generators (owned here; controlled by variables set from the test)
    int tick_div = 1;
    int tach_period = 50;
    bit gen_on = 1'b0;
    int shot_req = 0;
    int tcnt = 0, pcnt = 0, shot_seen = 0, shot_left = 0;

    always @(negedge clk) begin
        if (tick_div <= 1) tick_90k <= 1'b1;
        else begin
            tick_90k <= (tcnt == 0);
            tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        end
        if (shot_req != shot_seen) begin
            shot_seen = shot_req;
            shot_left = 10;
        end
        if (shot_left > 0) begin
            tach_in <= 1'b1;
            shot_left--;
        end else if (gen_on) begin
            tach_in <= (pcnt < tach_period / 2);
            pcnt = (pcnt + 1 >= tach_period) ? 0 : pcnt + 1;
        end else
            tach_in <= 1'b0;
    end

    // Behavioural reference model
    bit        hist[$] = '{0, 0, 0};
    int        ph = 0;
    int        m_cnt = 0;
    int        m_pub = 'hFFFF, m_shadow = 0, m_latch = 0;
    bit        m_pend = 0, m_lock = 0, m_stall = 0, m_valid = 0;

    function automatic int stall_code(input logic [1:0] d);
        if (d == 2'b00) return 'hFFFC;
        if (d == 2'b01) return 'hFFFE;
        return 'hFFFF;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = '{0, 0, 0};
            ph = 0; m_cnt = 0; m_pub = 'hFFFF; m_shadow = 0; m_latch = 0;
            m_pend = 0; m_lock = 0; m_stall = 0; m_valid = 0;
        end else begin
            bit rise, res, rel, nv;
            int rv, inc, sc, old_pub;
            rise = hist[1] && !hist[2];
            sc = stall_code(dur_sel);
            res = 0; rv = 0;
            inc = m_cnt + (tick_90k ? 1 : 0);
            if (pwm_duty == 8'h00) ph = 4;
            else if (ph == 4) ph = 0;
            else if (ph == 0 || ph == 3) begin
                if (rise) begin ph = 1; m_cnt = 0; end
            end else begin
                if (rise && ph == 2) begin
                    res = 1; rv = (inc >= sc) ? sc : inc;
                    m_stall = 0; m_cnt = 0; ph = 1;
                end else if (inc >= sc) begin
                    res = 1; rv = sc; m_stall = 1; m_cnt = sc; ph = 3;
                end else begin
                    m_cnt = inc;
                    if (rise) ph = 2;
                end
            end
            old_pub = m_pub;
            rel = rd_hi && m_lock && !rd_lo;
            nv = 0;
            if (rel) begin
                m_lock = 0;
                if (res) begin m_pub = rv; nv = 1; end
                else if (m_pend) begin m_pub = m_shadow; nv = 1; end
                m_pend = 0;
            end else if (res) begin
                if (m_lock || rd_lo) begin m_shadow = rv; m_pend = 1; end
                else begin m_pub = rv; nv = 1; end
            end
            if (rd_lo) begin m_lock = 1; m_latch = old_pub >> 8; end
            m_valid = nv;
            hist.push_front(tach_in);
            void'(hist.pop_back());
        end
    end

    // Per-clock comparison, half a period after the updating edge
    int cmp_total = 0, cmp_bad = 0, vcount = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            int eh;
            eh = m_lock ? m_latch : (m_pub >> 8) & 'hFF;
            cmp_total += 4;
            if (rd_lo_data !== 8'(m_pub & 'hFF)) begin
                cmp_bad++; $display("FAIL R6 lo byte act=%h exp=%h", rd_lo_data, m_pub & 'hFF);
            end
            if (rd_hi_data !== 8'(eh)) begin
                cmp_bad++; $display("FAIL R6 hi byte act=%h exp=%h", rd_hi_data, eh);
            end
            if (stall !== (m_stall && fan_en)) begin
                cmp_bad++; $display("FAIL R8 stall act=%b exp=%b", stall, m_stall && fan_en);
            end
            if (valid !== m_valid) begin
                cmp_bad++; $display("FAIL R7 valid act=%b exp=%b", valid, m_valid);
            end
            if (valid) vcount++;
        end
    end

    // Watchdog
    bit wd_fire = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) wd_fire = 1;
    end

    int total = 0, bad = 0;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_pair(output int v);
        int lo, hi;
        @(negedge clk); rd_lo = 1'b1; #1 lo = rd_lo_data;
        @(negedge clk); rd_lo = 1'b0;
        @(negedge clk); rd_hi = 1'b1; #1 hi = rd_hi_data;
        @(negedge clk); rd_hi = 1'b0;
        v = (hi << 8) | lo;
    endtask

    initial begin
        fork
            begin : tests
                int v, v0, lo_cap, hi_cap;
                wait_cyc(5);
                rst_n = 1'b1;
                #1;
                // R3: reset state
                check("R3 reading lo", rd_lo_data, 'hFF);
                check("R3 reading hi", rd_hi_data, 'hFF);
                check("R3 stall", stall, 0);
                check("R3 valid", valid, 0);

                // R1/R2: tick every clock, tach period 50 clocks
                tick_div = 1; tach_period = 50; gen_on = 1;
                wait_cyc(400);
                read_pair(v);
                check("R1 period count 1:1 ticks", v, 100);
                v0 = vcount;
                wait_cyc(300);
                check("R2 one reading per revolution", vcount - v0, 3);

                // R1: tick every 4 clocks, tach period 80
                tick_div = 4; tach_period = 80;
                wait_cyc(600);
                read_pair(v);
                check("R1 period count 1:4 ticks", v, 40);

                // R6/R7: lock and shadow
                tick_div = 1; tach_period = 50;
                wait_cyc(400);
                @(negedge clk); rd_lo = 1'b1; #1 lo_cap = rd_lo_data;
                @(negedge clk); rd_lo = 1'b0;
                tach_period = 150;
                wait_cyc(800);
                rd_hi = 1'b1; #1 hi_cap = rd_hi_data;
                check("R6 pair coherent under lock", (hi_cap << 8) | lo_cap, 100);
                @(negedge clk); rd_hi = 1'b0; #1;
                check("R7 publish at high read valid", valid, 1);
                check("R7 shadow published", (rd_hi_data << 8) | rd_lo_data, 300);

                // R5: suspension at zero duty
                pwm_duty = 8'h00; tach_period = 50;
                v0 = vcount;
                wait_cyc(500);
                check("R5 no publish while suspended", vcount - v0, 0);
                read_pair(v);
                check("R5 reading held", v, 300);
                pwm_duty = 8'h40;
                wait_cyc(600);
                read_pair(v);
                check("R5 resumes measuring", v, 100);

                // R4/R8: stall with dur 00, fan disabled
                fan_en = 1'b0; dur_sel = 2'b00; gen_on = 0;
                wait_cyc(66000);
                read_pair(v);
                check("R4 stall code dur 00", v, 'hFFFC);
                check("R8 stall masked by fan_en", stall, 0);
                fan_en = 1'b1; #1;
                check("R8 stall shown with fan_en", stall, 1);

                // R4: dur 01 after a single restart edge
                dur_sel = 2'b01;
                @(negedge clk); shot_req = shot_req + 1;
                wait_cyc(66000);
                read_pair(v);
                check("R4 stall code dur 01", v, 'hFFFE);
                check("R4 stall still set", stall, 1);

                // R4: recovery on normal pulses
                dur_sel = 2'b11; tach_period = 50; gen_on = 1;
                wait_cyc(400);
                check("R4 stall cleared", stall, 0);
                read_pair(v);
                check("R4 recovered reading", v, 100);
            end
            begin : guard
                wait (wd_fire);
            end
        join_any
        if (wd_fire) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog expired act=%0d exp=<180000", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total + cmp_total, bad + cmp_bad);
        $finish;
    end
endmodule